// File: doc/BRIEF.md
# Byte/Word Packer for a DMA Buffer

This block joins a byte-wide FIFO to a 16-bit DMA buffer register. In receive mode it gathers bytes leaving the FIFO into a two-slot holding stage and presents them as one 16-bit word. In transmit mode it takes 16-bit words from the DMA side and hands them to the FIFO one byte at a time. A byte-order pin decides whether the first byte of a pair belongs in the upper or the lower half of the word. The FIFO storage is outside the block: it appears only as a byte stream plus its current fill count and free count.

The block also raises a DMA request. The request tracks the FIFO level against a programmable threshold and drops early in the transfer cycle that would leave too little data or space for another word. Bytes marked with a tag bit never travel inside a word. They leave through a separate tag port, where a host drains them one at a time.

Every data interface is valid/ready. A transfer happens on a rising clock edge when both valid and ready are high. While valid is high and ready is low, the source holds its data steady. Ready is allowed to depend on valid. The request pin, the direction pin, the byte-order pin and the threshold-write pins are plain control signals.

Top module: `word_packer`

## Requirements
- R1: With `hi_first`=1, the first byte of a pair occupies word bits 15:8. In receive this is the first byte taken from the FIFO. In transmit this is the first byte emitted. In transmit, the order is captured at the edge that accepts the word.
- R2: With `hi_first`=0, the first byte of a pair occupies word bits 7:0 in both directions. A later change of `hi_first` does not reorder a transmit word that is already accepted.
- R3: In receive, a single held byte never forms a word. `dma_rd_valid` stays low and `fifo_rd_ready` stays high until a second byte arrives.
- R4: A byte taken with `fifo_rd_tag`=1 never appears on `dma_rd_data`. `dma_rd_valid` stays low while any held byte is tagged. The oldest tagged byte is shown on `tag_data` with `tag_valid`=1, and a `tag_ready` handshake removes it. A remaining older untagged byte stays first in order.
- R5: In receive, `dma_req` is high only when a complete untagged word is held and `fifo_used` is at least the effective threshold. Data must therefore reach the threshold plus two bytes.
- R6: In transmit, `dma_req` is high only when the holding register is empty (`dma_wr_ready`=1) and `fifo_free` is at least the effective threshold.
- R7: In a cycle with a DMA-side handshake, `dma_req` is low if that word is the last possible one. In receive, this is when `fifo_used` is below 2 or the FIFO head byte (`fifo_rd_valid`=1) is tagged. In transmit, this is when `fifo_free` is below 4.
- R8: A `thr_wr` pulse loads `thr_val` at that clock edge, so the new value governs `dma_req` from the next cycle. A stored value of 0 acts as 1. After reset the threshold is `THR_RST` (default 4).
- R9: With `dir_tx`=1, `fifo_rd_ready`, `dma_rd_valid` and `tag_valid` are low. With `dir_tx`=0, `dma_wr_ready` and `fifo_wr_valid` are low.
- R10: When the receive word or the transmit byte is valid and not accepted, it stays valid with unchanged data in the next cycle.
- R11: After reset the holding stages are empty. `dma_rd_valid`, `fifo_wr_valid`, `tag_valid` and `dma_req` are low, and the ready output of the active direction is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_tx | input | 1 | 0 = receive (FIFO to DMA), 1 = transmit |
| hi_first | input | 1 | 1 = first byte is bits 15:8, 0 = bits 7:0 |
| thr_wr | input | 1 | Load `thr_val` into the threshold register |
| thr_val | input | CW | New threshold value |
| fifo_used | input | CW | Bytes currently in the FIFO |
| fifo_free | input | CW | Free byte places in the FIFO |
| fifo_rd_valid | input | 1 | FIFO head byte available |
| fifo_rd_data | input | 8 | FIFO head byte |
| fifo_rd_tag | input | 1 | FIFO head byte is tagged |
| fifo_rd_ready | output | 1 | Block takes the head byte |
| dma_rd_valid | output | 1 | Packed word available |
| dma_rd_data | output | 16 | Packed word |
| dma_rd_ready | input | 1 | DMA side takes the word |
| tag_valid | output | 1 | A tagged byte is held |
| tag_data | output | 8 | Oldest tagged byte |
| tag_ready | input | 1 | Host removes the tagged byte |
| dma_wr_valid | input | 1 | Word from DMA side available |
| dma_wr_data | input | 16 | Word to unpack |
| dma_wr_ready | output | 1 | Block takes the word |
| fifo_wr_valid | output | 1 | Byte for the FIFO available |
| fifo_wr_data | output | 8 | Byte for the FIFO |
| fifo_wr_ready | input | 1 | FIFO takes the byte |
| dma_req | output | 1 | DMA service request |

## Verification
The assertions assume that `hi_first` stays steady while a received word waits for acceptance. They also assume that `dir_tx` changes only when both holding stages are empty. Under those two conditions, a change of order or direction cannot legally alter a held word. The stimulus changes `hi_first` only between completed receive words, or while a transmit word is held (in which case the order is already captured). It switches direction only after every word and byte has been drained. The FIFO counts are free-running numbers from the bench, and the checks treat them as given levels, not as a model of real storage.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 2 * LANE_W;

  typedef struct packed {
    logic              tag;
    logic [LANE_W-1:0] data;
  } slot_t;
endpackage

// File: rtl/wp_thresh.sv
`timescale 1ns/1ps
module wp_thresh #(
  parameter int CW      = 6,
  parameter int THR_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] val,
  output logic [CW-1:0] eff
);
  localparam logic [CW-1:0] RST_V = CW'(THR_RST);
  localparam logic [CW-1:0] MIN_V = CW'(1);

  logic [CW-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  thr_q <= RST_V;
    else if (wr) thr_q <= val;
  end

  // a zero setting would request forever; clamp to one
  assign eff = (thr_q == '0) ? MIN_V : thr_q;
endmodule

// File: rtl/wp_rx_pack.sv
`timescale 1ns/1ps
module wp_rx_pack
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hi_first,
  input  logic              in_valid,
  input  logic [LANE_W-1:0] in_data,
  input  logic              in_tag,
  output logic              in_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  input  logic              word_ready,
  output logic              tag_valid,
  output logic [LANE_W-1:0] tag_data,
  input  logic              tag_ready
);
  slot_t       s0_q, s1_q, s0_d, s1_d;
  logic [1:0]  cnt_q, cnt_d;
  logic        tag0, tag1;

  assign tag0       = (cnt_q != 2'd0) && s0_q.tag;
  assign tag1       = (cnt_q == 2'd2) && s1_q.tag;
  assign in_ready   = en && (cnt_q != 2'd2);
  assign word_valid = en && (cnt_q == 2'd2) && !s0_q.tag && !s1_q.tag;
  assign tag_valid  = en && (tag0 || tag1);
  assign tag_data   = tag0 ? s0_q.data : s1_q.data;
  assign word_data  = hi_first ? {s0_q.data, s1_q.data} : {s1_q.data, s0_q.data};

  always_comb begin
    s0_d  = s0_q;
    s1_d  = s1_q;
    cnt_d = cnt_q;
    // removal first, then append into the first free slot
    if (word_valid && word_ready) begin
      cnt_d = 2'd0;
    end else if (tag_valid && tag_ready) begin
      if (tag0) begin
        s0_d  = s1_q;
        cnt_d = cnt_q - 2'd1;
      end else begin
        cnt_d = 2'd1;
      end
    end
    if (in_valid && in_ready) begin
      if (cnt_d == 2'd0) s0_d = '{tag: in_tag, data: in_data};
      else               s1_d = '{tag: in_tag, data: in_data};
      cnt_d = cnt_d + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      s0_q  <= '0;
      s1_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      s0_q  <= s0_d;
      s1_q  <= s1_d;
    end
  end
endmodule

// File: rtl/wp_tx_unpack.sv
`timescale 1ns/1ps
module wp_tx_unpack
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hi_first,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_data,
  input  logic              out_ready
);
  logic [WORD_W-1:0] w_q;
  logic [1:0]        left_q;
  logic              hi_q;
  logic [LANE_W-1:0] first_b, second_b;

  assign word_ready = en && (left_q == 2'd0);
  assign out_valid  = en && (left_q != 2'd0);
  assign first_b    = hi_q ? w_q[WORD_W-1:LANE_W] : w_q[LANE_W-1:0];
  assign second_b   = hi_q ? w_q[LANE_W-1:0]      : w_q[WORD_W-1:LANE_W];
  assign out_data   = (left_q == 2'd2) ? first_b : second_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q    <= '0;
      left_q <= 2'd0;
      hi_q   <= 1'b0;
    end else if (word_valid && word_ready) begin
      w_q    <= word_data;
      hi_q   <= hi_first;
      left_q <= 2'd2;
    end else if (out_valid && out_ready) begin
      left_q <= left_q - 2'd1;
    end
  end
endmodule

// File: rtl/wp_req.sv
`timescale 1ns/1ps
module wp_req #(
  parameter int CW = 6
) (
  input  logic          dir_tx,
  input  logic [CW-1:0] thr,
  input  logic [CW-1:0] fifo_used,
  input  logic [CW-1:0] fifo_free,
  input  logic          rx_word_valid,
  input  logic          rx_xfer,
  input  logic          rx_head_tag,
  input  logic          tx_ready,
  input  logic          tx_xfer,
  output logic          req
);
  localparam logic [CW-1:0] PAIR  = CW'(2);
  localparam logic [CW-1:0] TWO_W = CW'(4);

  logic rx_ok, rx_last, tx_ok, tx_last;

  assign rx_ok   = rx_word_valid && (fifo_used >= thr);
  assign rx_last = rx_xfer && ((fifo_used < PAIR) || rx_head_tag);
  assign tx_ok   = tx_ready && (fifo_free >= thr);
  assign tx_last = tx_xfer && (fifo_free < TWO_W);
  assign req     = dir_tx ? (tx_ok && !tx_last) : (rx_ok && !rx_last);
endmodule

// File: rtl/word_packer.sv
`timescale 1ns/1ps
module word_packer
  import wp_pkg::*;
#(
  parameter int CW      = 6,
  parameter int THR_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_tx,
  input  logic              hi_first,
  input  logic              thr_wr,
  input  logic [CW-1:0]     thr_val,
  input  logic [CW-1:0]     fifo_used,
  input  logic [CW-1:0]     fifo_free,
  input  logic              fifo_rd_valid,
  input  logic [LANE_W-1:0] fifo_rd_data,
  input  logic              fifo_rd_tag,
  output logic              fifo_rd_ready,
  output logic              dma_rd_valid,
  output logic [WORD_W-1:0] dma_rd_data,
  input  logic              dma_rd_ready,
  output logic              tag_valid,
  output logic [LANE_W-1:0] tag_data,
  input  logic              tag_ready,
  input  logic              dma_wr_valid,
  input  logic [WORD_W-1:0] dma_wr_data,
  output logic              dma_wr_ready,
  output logic              fifo_wr_valid,
  output logic [LANE_W-1:0] fifo_wr_data,
  input  logic              fifo_wr_ready,
  output logic              dma_req
);
  logic [CW-1:0] thr_eff;

  wp_thresh #(.CW(CW), .THR_RST(THR_RST)) u_thr (
    .clk(clk), .rst_n(rst_n), .wr(thr_wr), .val(thr_val), .eff(thr_eff)
  );

  wp_rx_pack u_rx (
    .clk(clk), .rst_n(rst_n), .en(!dir_tx), .hi_first(hi_first),
    .in_valid(fifo_rd_valid), .in_data(fifo_rd_data), .in_tag(fifo_rd_tag),
    .in_ready(fifo_rd_ready),
    .word_valid(dma_rd_valid), .word_data(dma_rd_data), .word_ready(dma_rd_ready),
    .tag_valid(tag_valid), .tag_data(tag_data), .tag_ready(tag_ready)
  );

  wp_tx_unpack u_tx (
    .clk(clk), .rst_n(rst_n), .en(dir_tx), .hi_first(hi_first),
    .word_valid(dma_wr_valid), .word_data(dma_wr_data), .word_ready(dma_wr_ready),
    .out_valid(fifo_wr_valid), .out_data(fifo_wr_data), .out_ready(fifo_wr_ready)
  );

  wp_req #(.CW(CW)) u_req (
    .dir_tx(dir_tx), .thr(thr_eff), .fifo_used(fifo_used), .fifo_free(fifo_free),
    .rx_word_valid(dma_rd_valid), .rx_xfer(dma_rd_valid && dma_rd_ready),
    .rx_head_tag(fifo_rd_valid && fifo_rd_tag),
    .tx_ready(dma_wr_ready), .tx_xfer(dma_wr_valid && dma_wr_ready),
    .req(dma_req)
  );
endmodule

// File: rtl/wp_chk.sv
`timescale 1ns/1ps
module wp_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_tx,
  input logic          hi_first,
  input logic [CW-1:0] fifo_used,
  input logic [CW-1:0] fifo_free,
  input logic          fifo_rd_ready,
  input logic          dma_rd_valid,
  input logic [15:0]   dma_rd_data,
  input logic          dma_rd_ready,
  input logic          tag_valid,
  input logic          dma_wr_valid,
  input logic          dma_wr_ready,
  input logic          fifo_wr_valid,
  input logic [7:0]    fifo_wr_data,
  input logic          fifo_wr_ready,
  input logic          dma_req
);
  // R4: a held tag blocks any word
  a_r4_tag_blocks_word: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_valid |-> !tag_valid);

  // R5: receive request only with a full untagged word
  a_r5_rx_req_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dir_tx) |-> dma_rd_valid);

  // R6: transmit request only with an empty holding register
  a_r6_tx_req_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dir_tx) |-> dma_wr_ready);

  // R7: last receive transfer drops the request
  a_r7_rx_last_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_tx && dma_rd_valid && dma_rd_ready && (fifo_used < CW'(2))) |-> !dma_req);

  // R7: last transmit transfer drops the request
  a_r7_tx_last_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_tx && dma_wr_valid && dma_wr_ready && (fifo_free < CW'(4))) |-> !dma_req);

  // R9: receive side silent in transmit
  a_r9_rx_idle_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    dir_tx |-> (!fifo_rd_ready && !dma_rd_valid && !tag_valid));

  // R9: transmit side silent in receive
  a_r9_tx_idle_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_tx |-> (!dma_wr_ready && !fifo_wr_valid));

  // R10: a waiting receive word stays put
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd_valid && !dma_rd_ready) |=>
      (dir_tx || (hi_first != $past(hi_first)) || (dma_rd_valid && $stable(dma_rd_data))));

  // R10: a waiting transmit byte stays put
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_valid && !fifo_wr_ready) |=>
      (!dir_tx || (fifo_wr_valid && $stable(fifo_wr_data))));
endmodule

bind word_packer wp_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .hi_first(hi_first),
  .fifo_used(fifo_used), .fifo_free(fifo_free), .fifo_rd_ready(fifo_rd_ready),
  .dma_rd_valid(dma_rd_valid), .dma_rd_data(dma_rd_data), .dma_rd_ready(dma_rd_ready),
  .tag_valid(tag_valid), .dma_wr_valid(dma_wr_valid), .dma_wr_ready(dma_wr_ready),
  .fifo_wr_valid(fifo_wr_valid), .fifo_wr_data(fifo_wr_data),
  .fifo_wr_ready(fifo_wr_ready), .dma_req(dma_req)
);

// File: tb/word_packer_tb_top.sv
`timescale 1ns/1ps
module word_packer_tb_top;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dir_tx = 1'b0, hi_first = 1'b1, thr_wr = 1'b0;
  logic [CW-1:0] thr_val = '0, fifo_used = '0, fifo_free = '0;
  logic          fifo_rd_valid = 1'b0, fifo_rd_tag = 1'b0;
  logic [7:0]    fifo_rd_data = '0;
  logic          fifo_rd_ready, dma_rd_valid, tag_valid;
  logic [15:0]   dma_rd_data;
  logic [7:0]    tag_data;
  logic          dma_rd_ready = 1'b0, tag_ready = 1'b0;
  logic          dma_wr_valid = 1'b0, fifo_wr_ready = 1'b0;
  logic [15:0]   dma_wr_data = '0;
  logic          dma_wr_ready, fifo_wr_valid, dma_req;
  logic [7:0]    fifo_wr_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  word_packer #(.CW(CW), .THR_RST(4)) dut_i (.*);

  // {hi_first, first byte, second byte, expected word}
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 8'hA5, 8'h3C, 16'hA53C},
    {1'b0, 8'hA5, 8'h3C, 16'h3CA5},
    {1'b1, 8'h00, 8'hFF, 16'h00FF},
    {1'b0, 8'h12, 8'h34, 16'h3412},
    {1'b0, 8'hFF, 8'h01, 16'h01FF},
    {1'b1, 8'h80, 8'h7F, 16'h807F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIFO-pack FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic t);
    fifo_rd_valid = 1'b1; fifo_rd_data = d; fifo_rd_tag = t;
    tick();
    fifo_rd_valid = 1'b0; fifo_rd_tag = 1'b0;
  endtask

  task automatic rd_word;
    dma_rd_ready = 1'b1;
    tick();
    dma_rd_ready = 1'b0;
  endtask

  task automatic set_thr(input logic [CW-1:0] v);
    thr_wr = 1'b1; thr_val = v;
    tick();
    thr_wr = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    check("R11 rd_valid", dma_rd_valid, 0);
    check("R11 tag_valid", tag_valid, 0);
    check("R11 req", dma_req, 0);
    check("R11 rd_ready", fifo_rd_ready, 1);
    check("R11 wr_valid", fifo_wr_valid, 0);

    // table walk: receive packing in both byte orders (R1, R2)
    for (int i = 0; i < 6; i++) begin
      hi_first = VEC[i][32];
      rx_byte(VEC[i][31:24], 1'b0);
      rx_byte(VEC[i][23:16], 1'b0);
      #1;
      check(VEC[i][32] ? "R1 word valid" : "R2 word valid", dma_rd_valid, 1);
      check(VEC[i][32] ? "R1 word data" : "R2 word data", dma_rd_data, VEC[i][15:0]);
      rd_word();
    end

    // R3: residue byte
    hi_first = 1'b1;
    rx_byte(8'h11, 1'b0);
    #1;
    check("R3 no word on one byte", dma_rd_valid, 0);
    check("R3 still accepting", fifo_rd_ready, 1);
    rx_byte(8'h22, 1'b0);
    #1;
    check("R3 word after second", dma_rd_data, 16'h1122);
    // R10: held while not taken
    tick(); #1;
    check("R10 rx valid held", dma_rd_valid, 1);
    check("R10 rx data held", dma_rd_data, 16'h1122);
    rd_word();

    // R4: tag at head
    rx_byte(8'h55, 1'b1);
    rx_byte(8'h66, 1'b0);
    #1;
    check("R4 tag valid", tag_valid, 1);
    check("R4 tag data", tag_data, 8'h55);
    check("R4 no word with tag", dma_rd_valid, 0);
    tag_ready = 1'b1; tick(); tag_ready = 1'b0;
    #1;
    check("R4 tag cleared", tag_valid, 0);
    rx_byte(8'h77, 1'b0);
    #1;
    check("R4 word after tag", dma_rd_data, 16'h6677);
    rd_word();

    // R4: tag in second slot
    rx_byte(8'h10, 1'b0);
    rx_byte(8'h20, 1'b1);
    #1;
    check("R4 second-slot tag", tag_data, 8'h20);
    check("R4 blocked word", dma_rd_valid, 0);
    tag_ready = 1'b1; tick(); tag_ready = 1'b0;
    rx_byte(8'h30, 1'b0);
    #1;
    check("R4 older byte kept first", dma_rd_data, 16'h1030);

    // R5/R8: threshold, word held, reset threshold 4
    fifo_used = 6'd3;
    #1;
    check("R8 reset threshold 4", dma_req, 0);
    thr_wr = 1'b1; thr_val = 6'd3;
    #0.5;
    check("R8 not yet effective", dma_req, 0);
    tick(); thr_wr = 1'b0;
    #1;
    check("R5 req at threshold", dma_req, 1);
    fifo_used = 6'd2;
    #1;
    check("R5 below threshold", dma_req, 0);
    set_thr(6'd0);
    fifo_used = 6'd1;
    #1;
    check("R8 zero acts as one", dma_req, 1);
    fifo_used = 6'd0;
    #1;
    check("R8 zero still needs one", dma_req, 0);

    // R7: receive last cycle
    fifo_used = 6'd1;
    dma_rd_ready = 1'b1;
    #1;
    check("R7 rx last drops req", dma_req, 0);
    tick(); dma_rd_ready = 1'b0;
    rx_byte(8'h01, 1'b0);
    rx_byte(8'h02, 1'b0);
    fifo_used = 6'd5;
    dma_rd_ready = 1'b1;
    #1;
    check("R7 rx non-last keeps req", dma_req, 1);
    tick(); dma_rd_ready = 1'b0;
    rx_byte(8'h03, 1'b0);
    rx_byte(8'h04, 1'b0);
    fifo_rd_valid = 1'b1; fifo_rd_tag = 1'b1; fifo_rd_data = 8'hEE;
    dma_rd_ready = 1'b1;
    #1;
    check("R7 rx tagged head drops req", dma_req, 0);
    check("R4 word not tagged", dma_rd_data, 16'h0304);
    tick();
    dma_rd_ready = 1'b0; fifo_rd_valid = 1'b0; fifo_rd_tag = 1'b0;
    #1;
    check("R4 pipe empty after read", dma_rd_valid, 0);

    // R9: direction gating
    dir_tx = 1'b1;
    #1;
    check("R9 rx ready off in tx", fifo_rd_ready, 0);
    check("R9 tx ready on", dma_wr_ready, 1);
    set_thr(6'd3);

    // R1 transmit, R10 hold
    hi_first = 1'b1;
    dma_wr_valid = 1'b1; dma_wr_data = 16'hBEEF;
    tick();
    dma_wr_valid = 1'b0;
    #1;
    check("R1 tx first byte", fifo_wr_data, 8'hBE);
    check("R1 tx valid", fifo_wr_valid, 1);
    tick(); #1;
    check("R10 tx byte held", fifo_wr_data, 8'hBE);
    fifo_wr_ready = 1'b1;
    tick(); #1;
    check("R1 tx second byte", fifo_wr_data, 8'hEF);
    tick(); fifo_wr_ready = 1'b0;
    #1;
    check("R6 empty again", dma_wr_ready, 1);

    // R2 transmit, order captured at acceptance
    hi_first = 1'b0;
    dma_wr_valid = 1'b1; dma_wr_data = 16'h1234;
    tick();
    dma_wr_valid = 1'b0; hi_first = 1'b1;
    #1;
    check("R2 tx first byte", fifo_wr_data, 8'h34);
    fifo_wr_ready = 1'b1;
    tick(); #1;
    check("R2 tx second byte", fifo_wr_data, 8'h12);
    tick(); fifo_wr_ready = 1'b0;

    // R6/R7 transmit request
    fifo_free = 6'd3;
    #1;
    check("R6 req at threshold", dma_req, 1);
    fifo_free = 6'd2;
    #1;
    check("R6 below threshold", dma_req, 0);
    fifo_free = 6'd3;
    dma_wr_valid = 1'b1; dma_wr_data = 16'hA0B1;
    #1;
    check("R7 tx last drops req", dma_req, 0);
    tick(); dma_wr_valid = 1'b0;
    #1;
    check("R6 no req while holding", dma_req, 0);
    fifo_wr_ready = 1'b1; tick(); tick(); fifo_wr_ready = 1'b0;
    fifo_free = 6'd8;
    dma_wr_valid = 1'b1;
    #1;
    check("R7 tx non-last keeps req", dma_req, 1);
    tick(); dma_wr_valid = 1'b0;
    #1;
    check("R9 rx word off in tx", dma_rd_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FIFO-pack FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule